// File: doc/BRIEF.md
# Prescaled Sample-Compare Pulse-Width Modulator

This block generates one pulse-width modulated output from three registers: a control word, a sample (duty) value and a period value. A prescaler divides the selected count source. Each prescaled step advances an up-counter that runs from zero to the period value plus one and then returns to zero, so one output period spans the period value plus two steps. The output is high while the counter is below the active sample value and low otherwise.

Writes to the sample and period registers first land in pending copies. The counter only uses new values at a wrap, so a period never changes part-way through. Four low-power requests (stop, doze, wait, debug) freeze the counter unless the matching keep-running bit in the control word is set. Software writes the control word with zero to shut the block down. This holds the output low and clears the counter and the prescaler.

The register port is a single-cycle write strobe with an address, plus a combinational read path on the same address.

Top module: `pulse_mod_top`

## Requirements
- R1: After reset, `pwmOut` is low and offsets 0x00, 0x0C and 0x10 all read back zero.
- R2: The register port decodes three offsets. Offset 0x00 is the control word: bit 0 enable, bits 15:4 prescaler code, bits 17:16 source, and the keep-running bits (bit 25 stop, bit 24 doze, bit 23 wait, bit 22 debug). Offset 0x0C holds the sample and offset 0x10 holds the period, each CNT_W bits wide. Reads return the stored fields, and all other bit positions read as zero.
- R3: With source 1 or 2, one output period lasts (period + 2) × (code + 1) clock cycles. Successive rising edges of `pwmOut` are exactly that far apart.
- R4: In each period, `pwmOut` is high for sample × (code + 1) clock cycles when sample ≤ period + 2.
- R5: A sample of 0 gives a constant-low output. A sample of at least period + 2 gives a constant-high output.
- R6: A sample or period write made while the counter is running does not change the current period; it applies from the next wrap. A write accepted in the same cycle as a wrap applies to the period that starts at that wrap.
- R7: Writing 0 to the control word drives `pwmOut` low on the next clock edge and holds it low. On re-enable, a fresh period starts, and it starts with its high portion.
- R8: Source 3 advances the prescaler only on clock edges where `lowTick` is high. Source 0 never advances it.
- R9: `lowPwrReq` bits [3:0] map to stop, doze, wait and debug. While any request bit is high and its keep-running bit is clear, the counter and `pwmOut` hold their values. While the keep-running bit is set, counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset for write and read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| lowTick | input | 1 | Slow-source count pulse used by source 3 |
| lowPwrReq | input | 4 | Low-power requests: stop, doze, wait, debug (bit 3 down to 0) |
| pwmOut | output | 1 | Modulated output |

## Verification
The delicate coincidence is a sample write arriving in the very cycle the counter wraps. In that cycle the shadow load and the register update happen together, and the new value must still reach the period that begins there. The bench finds the wrap from an observed rising edge of `pwmOut` and times the write to land exactly on the next wrap. It then counts high cycles across the following period and expects the new width rather than the old one. The complementary case, a write placed mid-period, must leave the rest of that period untouched.

// File: rtl/pulse_mod_pkg.sv
package pulse_mod_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int PRE_W  = 12;
  localparam int LP_N   = 4;

  localparam logic [ADDR_W-1:0] CTRL_OFF   = 5'h00;
  localparam logic [ADDR_W-1:0] SAMPLE_OFF = 5'h0C;
  localparam logic [ADDR_W-1:0] PERIOD_OFF = 5'h10;

  localparam int EN_BIT  = 0;
  localparam int PRE_LSB = 4;
  localparam int SRC_LSB = 16;
  localparam int LP_LSB  = 22;

  typedef enum logic [1:0] {
    SRC_NONE     = 2'd0,
    SRC_BUS      = 2'd1,
    SRC_BUS_FAST = 2'd2,
    SRC_SLOW     = 2'd3
  } srcSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;      // block enabled
    logic advance;  // one source tick, not frozen
  } pwmStrobe_t;

endpackage

// File: rtl/pulse_mod_ctrl.sv
module pulse_mod_ctrl
  import pulse_mod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              lowTick,
  input  logic [LP_N-1:0]   lowPwrReq,
  output pwmStrobe_t        strobe,
  output logic [PRE_W-1:0]  preDiv,
  output logic [CNT_W-1:0]  nextSample,
  output logic [CNT_W-1:0]  nextPeriod
);

  logic             enQ;
  logic [PRE_W-1:0] preQ;
  srcSel_t          srcQ;
  logic [LP_N-1:0]  keepQ;
  logic [CNT_W-1:0] sampleQ;
  logic [CNT_W-1:0] periodQ;

  logic wrCtrl, wrSample, wrPeriod;
  logic srcTick;
  logic frozen;
  logic [DATA_W-1:0] ctrlView;
  logic unusedBits;

  assign wrCtrl   = wrEn && (addr == CTRL_OFF);
  assign wrSample = wrEn && (addr == SAMPLE_OFF);
  assign wrPeriod = wrEn && (addr == PERIOD_OFF);

  assign unusedBits = ^{wrData[DATA_W-1:LP_LSB+LP_N], wrData[LP_LSB-1:SRC_LSB+2],
                        wrData[PRE_LSB-1:EN_BIT+1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      preQ    <= '0;
      srcQ    <= SRC_NONE;
      keepQ   <= '0;
      sampleQ <= '0;
      periodQ <= '0;
    end else begin
      if (wrCtrl) begin
        enQ   <= wrData[EN_BIT];
        preQ  <= wrData[PRE_LSB +: PRE_W];
        srcQ  <= srcSel_t'(wrData[SRC_LSB +: 2]);
        keepQ <= wrData[LP_LSB +: LP_N];
      end
      if (wrSample) sampleQ <= wrData[CNT_W-1:0];
      if (wrPeriod) periodQ <= wrData[CNT_W-1:0];
    end
  end

  // Pending values seen by the shadow load, with write bypass
  assign nextSample = wrSample ? wrData[CNT_W-1:0] : sampleQ;
  assign nextPeriod = wrPeriod ? wrData[CNT_W-1:0] : periodQ;
  assign preDiv     = preQ;

  always_comb begin
    case (srcQ)
      SRC_BUS, SRC_BUS_FAST: srcTick = 1'b1;
      SRC_SLOW:              srcTick = lowTick;
      default:               srcTick = 1'b0;
    endcase
  end

  // Request bit i is stop/doze/wait/debug for i = 3..0
  assign frozen = |(lowPwrReq & ~keepQ);

  assign strobe.run     = enQ;
  assign strobe.advance = enQ && srcTick && !frozen;

  always_comb begin
    ctrlView = '0;
    ctrlView[EN_BIT]             = enQ;
    ctrlView[PRE_LSB +: PRE_W]   = preQ;
    ctrlView[SRC_LSB +: 2]       = srcQ;
    ctrlView[LP_LSB +: LP_N]     = keepQ;
  end

  always_comb begin
    case (addr)
      CTRL_OFF:   rdData = ctrlView;
      SAMPLE_OFF: rdData = DATA_W'(sampleQ);
      PERIOD_OFF: rdData = DATA_W'(periodQ);
      default:    rdData = '0;
    endcase
  end

  assert_wr_sample_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrSample |=> (rdData == DATA_W'($past(wrData[CNT_W-1:0])) || addr != SAMPLE_OFF));

  assert_ctrl_zero_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && wrData == '0) |=> !strobe.run && !strobe.advance);

endmodule

// File: rtl/pulse_mod_dp.sv
module pulse_mod_dp
  import pulse_mod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic [PRE_W-1:0] preDiv,
  input  logic [CNT_W-1:0] nextSample,
  input  logic [CNT_W-1:0] nextPeriod,
  output logic             pwmOut
);

  localparam int CW1 = CNT_W + 1;

  logic [PRE_W-1:0] preCntQ;
  logic [CW1-1:0]   cntQ;
  logic [CNT_W-1:0] actSampleQ;
  logic [CNT_W-1:0] actPeriodQ;
  logic             outQ;

  logic [CW1-1:0] cntTop;
  logic           stepEn;
  logic           wrapHit;
  logic           belowSample;

  assign cntTop      = {1'b0, actPeriodQ} + CW1'(1);
  assign stepEn      = strobe.advance && (preCntQ == preDiv);
  assign wrapHit     = (cntQ == cntTop);
  assign belowSample = (cntQ < {1'b0, actSampleQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCntQ    <= '0;
      cntQ       <= '0;
      actSampleQ <= '0;
      actPeriodQ <= '0;
      outQ       <= 1'b0;
    end else if (!strobe.run) begin
      preCntQ    <= '0;
      cntQ       <= '0;
      actSampleQ <= nextSample;
      actPeriodQ <= nextPeriod;
      outQ       <= 1'b0;
    end else if (strobe.advance) begin
      outQ <= belowSample;
      if (stepEn) begin
        preCntQ <= '0;
        if (wrapHit) begin
          cntQ       <= '0;
          actSampleQ <= nextSample;
          actPeriodQ <= nextPeriod;
        end else begin
          cntQ <= cntQ + CW1'(1);
        end
      end else begin
        preCntQ <= preCntQ + PRE_W'(1);
      end
    end
  end

  assign pwmOut = outQ;

  assert_off_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (!pwmOut && cntQ == '0 && preCntQ == '0));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> cntQ <= cntTop);

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    cntQ != '0 |-> ($stable(actSampleQ) && $stable(actPeriodQ)));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !strobe.advance) |=> ($stable(cntQ) && $stable(pwmOut) && $stable(preCntQ)));

endmodule

// File: rtl/pulse_mod_top.sv
module pulse_mod_top
  import pulse_mod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              lowTick,
  input  logic [LP_N-1:0]   lowPwrReq,
  output logic              pwmOut
);

  pwmStrobe_t       strobe;
  logic [PRE_W-1:0] preDiv;
  logic [CNT_W-1:0] nextSample;
  logic [CNT_W-1:0] nextPeriod;

  pulse_mod_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .rdData     (rdData),
    .lowTick    (lowTick),
    .lowPwrReq  (lowPwrReq),
    .strobe     (strobe),
    .preDiv     (preDiv),
    .nextSample (nextSample),
    .nextPeriod (nextPeriod)
  );

  pulse_mod_dp #(.CNT_W(CNT_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .preDiv     (preDiv),
    .nextSample (nextSample),
    .nextPeriod (nextPeriod),
    .pwmOut     (pwmOut)
  );

endmodule

// File: tb/pulse_mod_top_test.sv
`timescale 1ns/1ps
module pulse_mod_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        lowTick = 1'b0;
  logic [3:0]  lowPwrReq = '0;
  logic        pwmOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_SMP  = 5'h0C;
  localparam logic [4:0] A_PER  = 5'h10;
  localparam logic [31:0] EN_BUS = 32'h0001_0001; // enable, source 1

  always #10 clk = ~clk;

  pulse_mod_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .lowTick(lowTick), .lowPwrReq(lowPwrReq), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic countHigh(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
  endtask

  task automatic waitRise(output bit ok);
    logic prev;
    ok = 0;
    @(negedge clk);
    prev = pwmOut;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && pwmOut) begin ok = 1; break; end
      prev = pwmOut;
    end
  endtask

  task automatic waitFall(output bit ok);
    logic prev;
    ok = 0;
    @(negedge clk);
    prev = pwmOut;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (prev && !pwmOut) begin ok = 1; break; end
      prev = pwmOut;
    end
  endtask

  task automatic setup(input int smp, input int per, input logic [31:0] ctrl);
    regWrite(A_CTRL, 32'h0);
    regWrite(A_SMP, smp);
    regWrite(A_PER, per);
    regWrite(A_CTRL, ctrl);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check(pwmOut == 1'b0, "R1 out after reset", pwmOut, 0);
    regRead(A_CTRL, d); check(d == 0, "R1 ctrl after reset", d, 0);
    regRead(A_SMP, d);  check(d == 0, "R1 sample after reset", d, 0);
    regRead(A_PER, d);  check(d == 0, "R1 period after reset", d, 0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    regWrite(A_CTRL, 32'hFFFF_FFFE);
    regRead(A_CTRL, d); check(d == 32'h03C3_FFF0, "R2 ctrl readback", d, 32'h03C3_FFF0);
    regWrite(A_SMP, 32'h1234_ABCD);
    regRead(A_SMP, d); check(d == 32'h0000_ABCD, "R2 sample readback", d, 32'hABCD);
    regWrite(A_PER, 32'h0000_5A5A);
    regRead(A_PER, d); check(d == 32'h0000_5A5A, "R2 period readback", d, 32'h5A5A);
    regRead(5'h04, d); check(d == 0, "R2 unmapped offset", d, 0);
    regWrite(A_CTRL, 32'h0);
  endtask

  task automatic testPeriod(input int per, input int code);
    bit ok;
    int gap;
    int expGap;
    expGap = (per + 2) * (code + 1);
    setup(1, per, EN_BUS | (code << 4));
    waitRise(ok);
    gap = 0;
    waitRise(ok);
    // count again precisely: measure from one rise to the next
    gap = 0;
    begin
      logic prev;
      prev = pwmOut;
      for (int i = 0; i < 5000; i++) begin
        @(negedge clk);
        gap++;
        if (!prev && pwmOut) break;
        prev = pwmOut;
      end
    end
    check(ok && gap == expGap, "R3 rise spacing", gap, expGap);
  endtask

  task automatic testDuty(input int smp, input int per, input int code, input int periods);
    int highs;
    int len;
    int expH;
    len  = (per + 2) * (code + 1);
    expH = smp * (code + 1) * periods;
    setup(smp, per, EN_BUS | (code << 4));
    repeat (2 * len) @(negedge clk);
    countHigh(len * periods, highs);
    check(highs == expH, "R4 high cycles", highs, expH);
  endtask

  task automatic testExtremes();
    int highs;
    setup(0, 3, EN_BUS);
    repeat (12) @(negedge clk);
    countHigh(25, highs);
    check(highs == 0, "R5 sample zero constant low", highs, 0);
    setup(5, 3, EN_BUS);
    repeat (12) @(negedge clk);
    countHigh(25, highs);
    check(highs == 25, "R5 sample at period+2 constant high", highs, 25);
  endtask

  task automatic testMidWrite();
    bit ok;
    int highs;
    int run;
    setup(50, 100, EN_BUS);
    waitFall(ok);
    regWrite(A_SMP, 80);
    countHigh(30, highs);
    check(ok && highs == 0, "R6 mid-period write held off", highs, 0);
    waitRise(ok);
    run = 1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!pwmOut) break;
      run++;
    end
    check(ok && run == 80, "R6 new sample after wrap", run, 80);
  endtask

  task automatic testWrapWrite();
    bit ok;
    int highs;
    setup(3, 8, EN_BUS);
    repeat (15) @(negedge clk);
    waitRise(ok);
    repeat (8) @(negedge clk);
    wrEn = 1'b1; addr = A_SMP; wrData = 32'd6;
    @(negedge clk);
    wrEn = 1'b0;
    countHigh(10, highs);
    check(ok && highs == 6, "R6 write in wrap cycle", highs, 6);
  endtask

  task automatic testDisable();
    int highs;
    logic [31:0] d;
    setup(2, 3, EN_BUS);
    repeat (12) @(negedge clk);
    regWrite(A_CTRL, 32'h0);
    countHigh(12, highs);
    check(highs == 0, "R7 low after disable", highs, 0);
    regRead(A_CTRL, d); check(d == 0, "R7 ctrl cleared", d, 0);
    regWrite(A_CTRL, EN_BUS);
    @(negedge clk); check(pwmOut == 1'b1, "R7 restart step0 high", pwmOut, 1);
    @(negedge clk); check(pwmOut == 1'b1, "R7 restart step1 high", pwmOut, 1);
    @(negedge clk); check(pwmOut == 1'b0, "R7 restart step2 low", pwmOut, 0);
  endtask

  task automatic testSources();
    int highs;
    setup(1, 1, 32'h0003_0001);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) lowTick = 1'b1;
      @(negedge clk) lowTick = 1'b0;
      repeat (2) @(negedge clk);
    end
    highs = 0;
    for (int t = 0; t < 12; t++) begin
      lowTick = 1'b1;
      @(negedge clk);
      lowTick = 1'b0;
      if (pwmOut) highs++;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (pwmOut) highs++;
      end
    end
    check(highs == 16, "R8 slow source steps", highs, 16);
    setup(1, 1, 32'h0000_0001);
    countHigh(20, highs);
    check(highs == 0, "R8 source zero idle", highs, 0);
  endtask

  task automatic testLowPower();
    int changes;
    int highs;
    logic ref0;
    setup(2, 3, EN_BUS);
    repeat (12) @(negedge clk);
    lowPwrReq = 4'b1000;
    @(negedge clk);
    ref0 = pwmOut;
    changes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwmOut != ref0) changes++;
    end
    check(changes == 0, "R9 stop request freezes", changes, 0);
    regWrite(A_CTRL, EN_BUS | 32'h0200_0000);
    countHigh(50, highs);
    check(highs == 20, "R9 stop keep-running bit", highs, 20);
    lowPwrReq = 4'b0001;
    @(negedge clk);
    ref0 = pwmOut;
    changes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwmOut != ref0) changes++;
    end
    check(changes == 0, "R9 debug request freezes", changes, 0);
    lowPwrReq = 4'b0000;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testPeriod(3, 0);
    testPeriod(3, 3);
    testDuty(2, 3, 0, 10);
    testDuty(2, 3, 3, 5);
    testDuty(7, 12, 1, 3);
    testExtremes();
    testMidWrite();
    testWrapWrite();
    testDisable();
    testSources();
    testLowPower();
    finishRun();
  end

endmodule